// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial slave engine of a small byte-addressed non-volatile store. During a write transfer it gathers the incoming data bytes into a page latch of eight entries. The low three bits of the running word address select the entry. Those bits step after every byte and wrap, while the upper address bits stay fixed for the whole transfer. A ninth byte therefore lands on the entry used by the first one.

When the transfer ends with a STOP, and at least one byte was latched, and the write-protect input is low, the block enters a timed busy period. The length of that period is a parameter, so a bench can use a short value while silicon can use one in the millisecond range. In the first cycles of busy the array write port steps through the page entries in ascending order and writes only the entries that were filled in this transfer. When the period ends the valid bits are cleared and busy drops. While busy is high, every transfer input is ignored. The slave engine uses busy to withhold its acknowledge.

Top module: `page_commit_unit`

## Requirements
- R1: Out of reset `busy` and `arrWe` are low.
- R2: A data byte is stored in the entry given by the low three bits of the word address loaded by `wrStart`, plus the number of bytes received before it, modulo 8. It is written to the array address formed from the upper five bits of that word address followed by the three-bit entry index.
- R3: If more than eight bytes arrive in one transfer, the entry index wraps from 7 to 0 and the later byte replaces the earlier one. Only the latest value of each entry is written.
- R4: No array write and no busy occur before `stopIn`. Busy rises in the cycle after the cycle in which `stopIn` is sampled high.
- R5: Busy stays high for exactly `BUSY_CYCLES` consecutive clock cycles.
- R6: If `wpIn` is high when `stopIn` is sampled, no busy period starts, no array location is written, and the latched bytes are discarded.
- R7: Only entries filled in the current transfer are written. Entries left over from an earlier transfer are not written again.
- R8: A transfer that loads a word address but carries no data byte starts no busy period.
- R9: Within busy, the array write port issues the valid entries one per cycle in ascending entry order, during the first eight cycles of busy.
- R10: While busy is high, `wrStart`, `dataStb` and `stopIn` have no effect. No new write is latched or committed afterwards.
- R11: `arrWe` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | One-cycle marker: write transfer begins, word address valid |
| wordAddr | input | 8 | Word address loaded with `wrStart` |
| dataStb | input | 1 | One-cycle strobe: a data byte was received |
| dataByte | input | 8 | Data byte qualified by `dataStb` |
| stopIn | input | 1 | One-cycle marker: STOP seen on the bus |
| wpIn | input | 1 | Write-protect level; high blocks the commit |
| busy | output | 1 | Internal write cycle in progress |
| arrWe | output | 1 | Array write enable |
| arrAddr | output | 8 | Array write address |
| arrData | output | 8 | Array write data |

## Verification
The bench tries several write patterns, and each one separates a different fault. A single byte shows the address mapping and the busy length. A three-byte page that starts at entry 6 wraps inside the page, which exposes errors in the carry into the upper bits and in the commit order. Nine bytes from entry 0 show the overwrite. An eight-byte transfer followed by a one-byte transfer shows whether stale entries are written again. The remaining patterns cover STOP with write protect high, an address-only transfer, and a complete transfer issued during busy. In each case the write count and the array contents must stay as they were.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_BUSY = 2'd2
  } pwcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPtr;     // take a new word address
    logic storeByte;   // latch data byte at current entry
    logic clearValid;  // drop every valid bit
  } pwcStrobe_t;

endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int PAGE_BITS   = 3,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStart,
  input  logic                 dataStb,
  input  logic                 stopIn,
  input  logic                 wpIn,
  input  logic                 anyValid,
  output pwcStrobe_t           strobe,
  output logic [PAGE_BITS-1:0] slotIdx,
  output logic                 scanOn,
  output logic                 busy
);

  localparam int PAGE_DEPTH = 1 << PAGE_BITS;
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);
  localparam int SCAN_W     = PAGE_BITS + 1;
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BUSY_CYCLES - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(PAGE_DEPTH);

  pwcState_e         state, stateNxt;
  logic [CNT_W-1:0]  busyCnt;
  logic [SCAN_W-1:0] scanCnt;
  logic              commitOk;
  logic              busyDone;

  assign commitOk = anyValid && !wpIn;
  assign busyDone = (state == ST_BUSY) && (busyCnt == CNT_LAST);

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (wrStart) begin
          strobe.loadPtr    = 1'b1;
          strobe.clearValid = 1'b1;
          stateNxt          = ST_XFER;
        end
      end
      ST_XFER: begin
        if (stopIn) begin
          if (commitOk) begin
            stateNxt = ST_BUSY;
          end else begin
            strobe.clearValid = 1'b1;
            stateNxt          = ST_IDLE;
          end
        end else if (wrStart) begin
          strobe.loadPtr    = 1'b1;
          strobe.clearValid = 1'b1;
        end else if (dataStb) begin
          strobe.storeByte = 1'b1;
        end
      end
      ST_BUSY: begin
        if (busyDone) begin
          strobe.clearValid = 1'b1;
          stateNxt          = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busyCnt <= '0;
      scanCnt <= '0;
    end else begin
      state <= stateNxt;
      if (state != ST_BUSY) begin
        busyCnt <= '0;
        scanCnt <= '0;
      end else begin
        busyCnt <= busyCnt + 1'b1;
        if (scanOn) scanCnt <= scanCnt + 1'b1;
      end
    end
  end

  assign busy    = (state == ST_BUSY);
  assign scanOn  = busy && (scanCnt < SCAN_LAST);
  assign slotIdx = scanCnt[PAGE_BITS-1:0];

  // R4: busy only begins after a sampled STOP
  p_rise_on_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopIn));

  // R6: a protected STOP never begins a write cycle
  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn));

  // R5: busy ends only after the full cycle count
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyCnt) == CNT_LAST));

  // R9: scan moves through entries one per cycle, ascending
  p_ascending_r9: assert property (@(posedge clk) disable iff (!rstN)
    scanOn |=> (scanCnt == $past(scanCnt) + 1'b1));

  // R10: no latch or address load while committing
  p_no_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.loadPtr || strobe.storeByte));

endmodule

// File: rtl/pwc_dpath.sv
module pwc_dpath
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pwcStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    wordAddr,
  input  logic [DATA_W-1:0]    dataByte,
  input  logic [PAGE_BITS-1:0] slotIdx,
  output logic                 anyValid,
  output logic                 slotValid,
  output logic [DATA_W-1:0]    slotData,
  output logic [ADDR_W-1:0]    commitAddr
);

  localparam int PAGE_DEPTH = 1 << PAGE_BITS;
  localparam int UPPER_W    = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0]    ptr;
  logic [PAGE_DEPTH-1:0] validVec;
  logic [DATA_W-1:0]    pageMem [PAGE_DEPTH];
  logic [PAGE_BITS-1:0] inSlot;
  logic [UPPER_W-1:0]   pageBase;

  assign inSlot   = ptr[PAGE_BITS-1:0];
  assign pageBase = ptr[ADDR_W-1:PAGE_BITS];

  // pointer: upper bits fixed, low bits wrap within the page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= wordAddr;
    end else if (strobe.storeByte) begin
      ptr <= {pageBase, inSlot + 1'b1};
    end
  end

  genvar g;
  generate
    for (g = 0; g < PAGE_DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (strobe.storeByte && (inSlot == PAGE_BITS'(g))) begin
          pageMem[g] <= dataByte;
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validVec[g] <= 1'b0;
        end else if (strobe.clearValid) begin
          validVec[g] <= 1'b0;
        end else if (strobe.storeByte && (inSlot == PAGE_BITS'(g))) begin
          validVec[g] <= 1'b1;
        end
      end
    end
  endgenerate

  assign anyValid   = |validVec;
  assign slotValid  = validVec[slotIdx];
  assign slotData   = pageMem[slotIdx];
  assign commitAddr = {pageBase, slotIdx};

  // R2: storing a byte never disturbs the page base
  p_upper_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeByte && !strobe.loadPtr) |=> $stable(ptr[ADDR_W-1:PAGE_BITS]));

  // R3: the last entry is followed by entry zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeByte && !strobe.loadPtr && (&inSlot)) |=> (inSlot == '0));

  // R7: a new address load leaves no valid entry behind
  p_fresh_xfer_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtr |=> !anyValid);

endmodule

// File: rtl/page_commit_unit.sv
module page_commit_unit
  import pwc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 3,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataByte,
  input  logic              stopIn,
  input  logic              wpIn,
  output logic              busy,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  pwcStrobe_t           strobe;
  logic [PAGE_BITS-1:0] slotIdx;
  logic                 scanOn;
  logic                 anyValid;
  logic                 slotValid;

  pwc_ctrl #(
    .PAGE_BITS  (PAGE_BITS),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStart (wrStart),
    .dataStb (dataStb),
    .stopIn  (stopIn),
    .wpIn    (wpIn),
    .anyValid(anyValid),
    .strobe  (strobe),
    .slotIdx (slotIdx),
    .scanOn  (scanOn),
    .busy    (busy)
  );

  pwc_dpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PAGE_BITS(PAGE_BITS)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordAddr  (wordAddr),
    .dataByte  (dataByte),
    .slotIdx   (slotIdx),
    .anyValid  (anyValid),
    .slotValid (slotValid),
    .slotData  (arrData),
    .commitAddr(arrAddr)
  );

  assign arrWe = scanOn && slotValid;

  // R11: the array port is quiet outside a write cycle
  p_we_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

endmodule

// File: tb/test_page_commit_unit.sv
module test_page_commit_unit;

  localparam int BUSY = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] wordAddr = '0;
  logic       dataStb = 1'b0;
  logic [7:0] dataByte = '0;
  logic       stopIn = 1'b0;
  logic       wpIn = 1'b0;
  logic       busy, arrWe;
  logic [7:0] arrAddr, arrData;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  page_commit_unit #(.BUSY_CYCLES(BUSY)) i_page_commit_unit (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wordAddr(wordAddr),
    .dataStb(dataStb), .dataByte(dataByte), .stopIn(stopIn), .wpIn(wpIn),
    .busy(busy), .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  // bench-side array model and write log
  logic [7:0] shadow [256];
  bit         written [256];
  logic [7:0] logAddr [64];
  int         logN = 0;
  int         weNoBusy = 0;
  int         busyRun = 0;
  int         lastLen = 0;

  always @(posedge clk) begin
    if (arrWe) begin
      shadow[arrAddr]  <= arrData;
      written[arrAddr] <= 1'b1;
      if (logN < 64) logAddr[logN] <= arrAddr;
      logN <= logN + 1;
      if (!busy) weNoBusy <= weNoBusy + 1;
    end
    if (busy) busyRun <= busyRun + 1;
    else if (busyRun != 0) begin
      lastLen <= busyRun;
      busyRun <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [7:0] a);
    @(negedge clk); wrStart = 1'b1; wordAddr = a;
    @(negedge clk); wrStart = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d);
    @(negedge clk); dataStb = 1'b1; dataByte = d;
    @(negedge clk); dataStb = 1'b0;
  endtask

  task automatic sendStop();
    @(negedge clk); stopIn = 1'b1;
    @(negedge clk); stopIn = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 4 * BUSY && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic clearLog();
    @(negedge clk); logN = 0;
  endtask

  task automatic testReset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 arrWe after reset", arrWe, 0);
  endtask

  task automatic testByteWrite();
    clearLog();
    doStart(8'h35);
    sendByte(8'hA7);
    repeat (3) @(negedge clk);
    chk("R4 no busy before stop", busy, 0);
    chk("R4 no write before stop", logN, 0);
    sendStop();
    chk("R4 busy after stop", busy, 1);
    waitIdle();
    chk("R5 busy length", lastLen, BUSY);
    chk("R2 byte data", shadow[8'h35], 8'hA7);
    chk("R2 write count", logN, 1);
  endtask

  task automatic testPageWrap();
    clearLog();
    doStart(8'h46);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    sendStop();
    waitIdle();
    chk("R2 entry 6", shadow[8'h46], 8'h11);
    chk("R2 entry 7", shadow[8'h47], 8'h22);
    chk("R2 wrapped entry 0 stays in page", shadow[8'h40], 8'h33);
    chk("R2 no carry into next page", written[8'h48], 0);
    chk("R9 write count", logN, 3);
    chk("R9 first addr", logAddr[0], 8'h40);
    chk("R9 second addr", logAddr[1], 8'h46);
    chk("R9 third addr", logAddr[2], 8'h47);
  endtask

  task automatic testOverwrite();
    clearLog();
    doStart(8'h80);
    for (int i = 0; i < 9; i++) sendByte(8'hC0 + 8'(i));
    sendStop();
    waitIdle();
    chk("R3 entry 0 overwritten", shadow[8'h80], 8'hC8);
    chk("R3 entry 1", shadow[8'h81], 8'hC1);
    chk("R3 entry 7", shadow[8'h87], 8'hC7);
    chk("R3 eight writes", logN, 8);
  endtask

  task automatic testProtect();
    clearLog();
    wpIn = 1'b1;
    doStart(8'h10);
    sendByte(8'h55);
    sendStop();
    chk("R6 no busy under protect", busy, 0);
    repeat (BUSY + 4) @(negedge clk);
    chk("R6 no write under protect", logN, 0);
    chk("R6 location untouched", written[8'h10], 0);
    wpIn = 1'b0;
    doStart(8'h11);
    sendByte(8'h66);
    sendStop();
    waitIdle();
    chk("R6 discarded byte not written later", written[8'h10], 0);
    chk("R6 later write proceeds", shadow[8'h11], 8'h66);
    chk("R6 single write", logN, 1);
  endtask

  task automatic testStale();
    doStart(8'h60);
    for (int i = 0; i < 8; i++) sendByte(8'hB0 + 8'(i));
    sendStop();
    waitIdle();
    clearLog();
    doStart(8'h62);
    sendByte(8'hEE);
    sendStop();
    waitIdle();
    chk("R7 only fresh entry written", logN, 1);
    chk("R7 fresh data", shadow[8'h62], 8'hEE);
    chk("R7 old entry kept", shadow[8'h60], 8'hB0);
  endtask

  task automatic testAddrOnly();
    clearLog();
    doStart(8'h20);
    sendStop();
    chk("R8 no busy", busy, 0);
    repeat (BUSY + 4) @(negedge clk);
    chk("R8 no write", logN, 0);
  endtask

  task automatic testBusyIgnore();
    clearLog();
    doStart(8'h30);
    sendByte(8'h5A);
    sendStop();
    doStart(8'h70);
    sendByte(8'h99);
    sendStop();
    waitIdle();
    chk("R10 busy length unchanged", lastLen, BUSY);
    repeat (BUSY + 4) @(negedge clk);
    chk("R10 no busy afterwards", busy, 0);
    chk("R10 one write only", logN, 1);
    chk("R10 ignored address untouched", written[8'h70], 0);
    chk("R11 write enable only during busy", weNoBusy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      shadow[i]  = '0;
      written[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testByteWrite();
    testPageWrap();
    testOverwrite();
    testProtect();
    testStale();
    testAddrOnly();
    testBusyIgnore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1ms;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule